// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block keeps track of the operating mode of a metering-style chip and decides which on-chip functions are powered in each mode. There are four modes: run (main supply present), brown (battery only, processor running), display-only and deep sleep. Firmware running in brown mode can park the chip in display-only or deep-sleep mode by writing a mode request. From either of those two modes, an enabled wake source brings the chip back to brown mode, never straight to run mode. When the main supply is present in brown mode, the chip moves on to run mode.

There are five wake sources: wake-timer expiry (high level), push-button press (high level), a rising edge on a designated edge pin, a high level on a designated level pin, and a falling edge (start-bit activity) on either the serial receive line or the optical receive line. All raw inputs pass through a two-stage synchroniser. Each source has its own enable bit. The cause of a wake is latched in sticky flags that firmware clears by writing ones.

A combinational enable map turns the current mode into a vector of function enables. It also produces a select that limits the processor clock to the fast rate when the fast-PLL bit is set. The map keeps the PLL on in display-only mode only when the display voltage mode selects boost.

Top module: `pwr_wake_ctl`

## Requirements
- R1: Mode encoding is run=2'b00, brown=2'b01, display=2'b10, sleep=2'b11. After reset the mode is brown and all wake flags are zero.
- R2: In brown mode, a main supply that is high for the synchroniser delay moves the mode to run. The mode changes on the third clock edge after the input rises. In run mode, loss of the main supply returns the mode to brown with the same delay. In display or sleep mode the supply input has no effect.
- R3: A mode request write is accepted only in brown mode with main supply absent. Code 2'b10 enters display and 2'b11 enters sleep on the next edge. Codes 2'b00 and 2'b01, and writes in any other mode, leave the mode unchanged.
- R4: In display or sleep mode, any enabled wake event moves the mode to brown on the third edge after the raw input changes, never directly to run.
- R5: Wake flag bit positions and triggers: bit0 timer high, bit1 push-button high, bit2 rising edge on the edge pin (a pin already high at entry does not wake), bit3 level pin high (sampled continuously), bit4 falling edge on either receive line.
- R6: A flag is set only by an enabled event in display or sleep mode. It stays set until a write-one-to-clear on its bit. A set and a clear in the same cycle leave the flag set.
- R7: A source whose enable bit is zero neither changes the mode nor sets its flag.
- R8: fn_en bits are PLL 0, CE 1, ADC 2, FIR 3, CPU clock 4, UART 5, flash 6, DIO 7, watchdog 8, LCD 9, LCD boost 10, wake timer 11, oscillator/RTC 12, temperature 13, NV RAM 14, battery measure 15. In sleep, fn_en is exactly 16'h7800.
- R9: In display mode, fn_en is 16'h7A00, plus bits 10 and 0 (16'h7E01) when lcd_vmode is 2'b10.
- R10: In run mode all bits are set except LCD boost, which follows lcd_vmode==2'b10. Brown mode is the same with ADC and FIR cleared and CE cleared when ce_halt is 1.
- R11: clk_fast_sel equals pll_fast in run and brown mode and is 0 in display and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr_ok | input | 1 | Main supply present (asynchronous) |
| mode_req_wr | input | 1 | Mode request write strobe |
| mode_req | input | 2 | Requested mode code |
| lcd_vmode | input | 2 | Display voltage mode, 2'b10 selects boost |
| pll_fast | input | 1 | Fast PLL select |
| ce_halt | input | 1 | Firmware halt of the computation engine in brown mode |
| wake_en | input | 5 | Per-source wake enables |
| wake_clr_wr | input | 1 | Flag clear write strobe |
| wake_clr | input | 5 | Write-one-to-clear mask |
| wkt_expired | input | 1 | Wake timer expired |
| pb_press | input | 1 | Push-button pressed |
| gpio_edge_pin | input | 1 | Rising-edge wake pin |
| gpio_level_pin | input | 1 | High-level wake pin |
| uart_rx | input | 1 | Serial receive line, idle high |
| opt_rx | input | 1 | Optical receive line, idle high |
| pm_mode | output | 2 | Current mode |
| wake_flags | output | 5 | Sticky wake cause flags |
| fn_en | output | 16 | Per-function enables |
| clk_fast_sel | output | 1 | Processor clock limit select |

## Verification
The assertions check on every cycle that a wake from display or sleep lands in brown mode and never in run. They also check that the low-power modes are entered only from brown, that flags are sticky unless cleared, that disabled sources set no flag, and that the sleep and display enable patterns hold. Only the bench scenarios can show the trigger type of each source. These include the edge pin that is already high at entry and the level pin that is enabled while held high. The same holds for the exact synchroniser latency, set-over-clear priority, and the supply input being ignored while asleep.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_BROWN = 2'b01,
    PM_LCD   = 2'b10,
    PM_SLEEP = 2'b11
  } pm_mode_e;

  localparam int NUM_SRC  = 5;
  localparam int SRC_TMR  = 0;
  localparam int SRC_PB   = 1;
  localparam int SRC_EDGE = 2;
  localparam int SRC_LVL  = 3;
  localparam int SRC_COMM = 4;

  localparam int NUM_FN     = 16;
  localparam int FN_PLL     = 0;
  localparam int FN_CE      = 1;
  localparam int FN_ADC     = 2;
  localparam int FN_FIR     = 3;
  localparam int FN_CPUCLK  = 4;
  localparam int FN_UART    = 5;
  localparam int FN_FLASH   = 6;
  localparam int FN_DIO     = 7;
  localparam int FN_WDT     = 8;
  localparam int FN_LCD     = 9;
  localparam int FN_BOOST   = 10;
  localparam int FN_WKT     = 11;
  localparam int FN_OSC     = 12;
  localparam int FN_TEMP    = 13;
  localparam int FN_NVRAM   = 14;
  localparam int FN_BATMEAS = 15;

  localparam logic [1:0] VMODE_BOOST = 2'b10;

  function automatic logic [NUM_FN-1:0] fn_bit(input int idx);
    logic [NUM_FN-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic [NUM_FN-1:0] keep_alive_set();
    return fn_bit(FN_WKT) | fn_bit(FN_OSC) | fn_bit(FN_TEMP) | fn_bit(FN_NVRAM);
  endfunction

  function automatic logic [NUM_FN-1:0] mode_enables(input pm_mode_e m,
                                                     input logic boost,
                                                     input logic ce_halt);
    logic [NUM_FN-1:0] v;
    case (m)
      PM_SLEEP: v = keep_alive_set();
      PM_LCD: begin
        v = keep_alive_set() | fn_bit(FN_LCD);
        if (boost) v = v | fn_bit(FN_BOOST) | fn_bit(FN_PLL);
      end
      PM_RUN: begin
        v = '1;
        if (!boost) v = v & ~fn_bit(FN_BOOST);
      end
      default: begin
        v = '1 & ~fn_bit(FN_ADC) & ~fn_bit(FN_FIR);
        if (!boost) v = v & ~fn_bit(FN_BOOST);
        if (ce_halt) v = v & ~fn_bit(FN_CE);
      end
    endcase
    return v;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import pwr_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmr_s,
  input  logic               pb_s,
  input  logic               edge_s,
  input  logic               lvl_s,
  input  logic               rx_s,
  input  logic               orx_s,
  input  logic               arm,
  input  logic [NUM_SRC-1:0] en,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] hit,
  output logic [NUM_SRC-1:0] flags
);
  logic edge_prev, rx_prev, orx_prev;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] clr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_prev <= 1'b0;
      rx_prev   <= 1'b1;
      orx_prev  <= 1'b1;
    end else begin
      edge_prev <= edge_s;
      rx_prev   <= rx_s;
      orx_prev  <= orx_s;
    end
  end

  always_comb begin
    evt           = '0;
    evt[SRC_TMR]  = tmr_s;
    evt[SRC_PB]   = pb_s;
    evt[SRC_EDGE] = edge_s & ~edge_prev;
    evt[SRC_LVL]  = lvl_s;
    evt[SRC_COMM] = (~rx_s & rx_prev) | (~orx_s & orx_prev);
  end

  assign hit     = evt & en & {NUM_SRC{arm}};
  assign clr_eff = clr_mask & {NUM_SRC{clr_wr}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[i] <= 1'b0;
      else if (hit[i])   flags[i] <= 1'b1;
      else if (clr_eff[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pwr_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok,
  input  logic       req_wr,
  input  logic [1:0] req,
  input  logic       wake_any,
  output pm_mode_e   mode
);
  pm_mode_e nxt;

  always_comb begin
    nxt = mode;
    case (mode)
      PM_RUN:   if (!main_ok) nxt = PM_BROWN;
      PM_BROWN: begin
        if (main_ok) nxt = PM_RUN;
        else if (req_wr && (req == PM_LCD || req == PM_SLEEP)) nxt = pm_mode_e'(req);
      end
      default:  if (wake_any) nxt = PM_BROWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= PM_BROWN;
    else        mode <= nxt;
  end
endmodule

// File: rtl/fn_enable_map.sv
module fn_enable_map
  import pwr_wake_pkg::*;
(
  input  pm_mode_e          mode,
  input  logic [1:0]        vmode,
  input  logic              ce_halt,
  input  logic              pll_fast,
  output logic [NUM_FN-1:0] fn_en,
  output logic              clk_fast
);
  logic awake;
  assign awake    = (mode == PM_RUN) || (mode == PM_BROWN);
  assign fn_en    = mode_enables(mode, vmode == VMODE_BOOST, ce_halt);
  assign clk_fast = pll_fast & awake;
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
  import pwr_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               main_pwr_ok,
  input  logic               mode_req_wr,
  input  logic [1:0]         mode_req,
  input  logic [1:0]         lcd_vmode,
  input  logic               pll_fast,
  input  logic               ce_halt,
  input  logic [NUM_SRC-1:0] wake_en,
  input  logic               wake_clr_wr,
  input  logic [NUM_SRC-1:0] wake_clr,
  input  logic               wkt_expired,
  input  logic               pb_press,
  input  logic               gpio_edge_pin,
  input  logic               gpio_level_pin,
  input  logic               uart_rx,
  input  logic               opt_rx,
  output logic [1:0]         pm_mode,
  output logic [NUM_SRC-1:0] wake_flags,
  output logic [NUM_FN-1:0]  fn_en,
  output logic               clk_fast_sel
);
  localparam int NRAW = 7;
  localparam logic [NRAW-1:0] RAW_IDLE = 7'b110_0000;

  logic [NRAW-1:0]    raw, syn;
  pm_mode_e           mode;
  logic               low_pwr;
  logic [NUM_SRC-1:0] wake_hit;
  logic               wake_any;

  assign raw = {opt_rx, uart_rx, gpio_level_pin, gpio_edge_pin,
                pb_press, wkt_expired, main_pwr_ok};

  wake_sync #(.W(NRAW), .STAGES(SYNC_STAGES), .RST_VAL(RAW_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign low_pwr  = (mode == PM_LCD) || (mode == PM_SLEEP);
  assign wake_any = |wake_hit;

  wake_detect u_det (
    .clk(clk), .rst_n(rst_n),
    .tmr_s(syn[1]), .pb_s(syn[2]), .edge_s(syn[3]), .lvl_s(syn[4]),
    .rx_s(syn[5]), .orx_s(syn[6]),
    .arm(low_pwr), .en(wake_en),
    .clr_wr(wake_clr_wr), .clr_mask(wake_clr),
    .hit(wake_hit), .flags(wake_flags)
  );

  pm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .main_ok(syn[0]),
    .req_wr(mode_req_wr), .req(mode_req), .wake_any(wake_any), .mode(mode)
  );

  fn_enable_map u_map (
    .mode(mode), .vmode(lcd_vmode), .ce_halt(ce_halt), .pll_fast(pll_fast),
    .fn_en(fn_en), .clk_fast(clk_fast_sel)
  );

  assign pm_mode = mode;
endmodule

// File: rtl/pwr_wake_ctl_chk.sv
module pwr_wake_ctl_chk
  import pwr_wake_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic               wake_any,
  input logic [NUM_SRC-1:0] wake_flags,
  input logic [NUM_SRC-1:0] wake_en,
  input logic               clr_wr,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic [NUM_FN-1:0]  fn_en,
  input logic [1:0]         lcd_vmode
);
  logic               is_low;
  logic [NUM_SRC-1:0] keep;
  assign is_low = (mode == PM_LCD) || (mode == PM_SLEEP);
  assign keep   = wake_flags & ~(clr_mask & {NUM_SRC{clr_wr}});

  assert_wake_to_brown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_low && wake_any) |=> (mode == PM_BROWN));

  assert_no_direct_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_low |=> (mode != PM_RUN));

  assert_low_only_from_brown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) |=> !is_low);

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_flags & $past(keep)) == $past(keep)));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_flags & ~$past(wake_flags) & ~$past(wake_en)) == '0));

  assert_sleep_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) |-> (fn_en == 16'h7800));

  assert_lcd_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_LCD) |-> (fn_en[FN_PLL] == (lcd_vmode == 2'b10)) && !fn_en[FN_UART]
                         && !fn_en[FN_CPUCLK] && fn_en[FN_LCD]);
endmodule

bind pwr_wake_ctl pwr_wake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(pm_mode), .wake_any(wake_any),
  .wake_flags(wake_flags), .wake_en(wake_en), .clr_wr(wake_clr_wr),
  .clr_mask(wake_clr), .fn_en(fn_en), .lcd_vmode(lcd_vmode)
);

// File: tb/pwr_wake_ctl_test.sv
module pwr_wake_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic main_pwr_ok = 0, mode_req_wr = 0, pll_fast = 0, ce_halt = 0;
  logic [1:0] mode_req = 0, lcd_vmode = 0;
  logic [4:0] wake_en = 5'h1F, wake_clr = 0;
  logic wake_clr_wr = 0, wkt_expired = 0, pb_press = 0;
  logic gpio_edge_pin = 0, gpio_level_pin = 0, uart_rx = 1, opt_rx = 1;
  logic [1:0] pm_mode;
  logic [4:0] wake_flags;
  logic [15:0] fn_en;
  logic clk_fast_sel;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwr_wake_ctl uut (.*);

  typedef struct packed {
    logic [1:0] m; logic [1:0] vm; logic halt; logic fast;
    logic [15:0] en; logic clkf;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 2'b10, 1'b0, 1'b1, 16'hFFFF, 1'b1},
    '{2'b00, 2'b00, 1'b1, 1'b0, 16'hFBFF, 1'b0},
    '{2'b01, 2'b10, 1'b0, 1'b1, 16'hFFF3, 1'b1},
    '{2'b01, 2'b00, 1'b1, 1'b1, 16'hFBF1, 1'b1},
    '{2'b10, 2'b10, 1'b0, 1'b1, 16'h7E01, 1'b0},
    '{2'b10, 2'b01, 1'b0, 1'b1, 16'h7A00, 1'b0},
    '{2'b11, 2'b10, 1'b0, 1'b1, 16'h7800, 1'b0},
    '{2'b11, 2'b00, 1'b1, 1'b0, 16'h7800, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_req(input logic [1:0] m);
    mode_req_wr = 1'b1; mode_req = m;
    tick(1);
    mode_req_wr = 1'b0;
  endtask

  task automatic to_brn();
    logic [4:0] saved;
    saved = wake_en;
    wake_en = 5'h1F; main_pwr_ok = 0; wkt_expired = 1;
    tick(4);
    wkt_expired = 0;
    tick(3);
    wake_clr_wr = 1; wake_clr = 5'h1F;
    tick(1);
    wake_clr_wr = 0; wake_clr = 0; wake_en = saved;
  endtask

  task automatic go(input logic [1:0] m);
    to_brn();
    if (m == 2'b00) begin main_pwr_ok = 1; tick(4); end
    else if (m != 2'b01) write_req(m);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 reset mode", pm_mode, 2'b01);
    check("R1 reset flags", wake_flags, 0);
    check("R10 brown enables after reset", fn_en, 16'hFBF3);
    check("R11 clock select after reset", clk_fast_sel, 0);

    // R2 supply latency both ways
    main_pwr_ok = 1; tick(2);
    check("R2 not yet run", pm_mode, 2'b01);
    tick(1);
    check("R2 run on supply", pm_mode, 2'b00);
    main_pwr_ok = 0; tick(3);
    check("R2 brown on supply loss", pm_mode, 2'b01);

    // R3 ignored requests
    write_req(2'b00);
    check("R3 code 00 ignored", pm_mode, 2'b01);
    write_req(2'b01);
    check("R3 code 01 ignored", pm_mode, 2'b01);
    main_pwr_ok = 1; tick(4);
    write_req(2'b10);
    check("R3 request in run ignored", pm_mode, 2'b00);

    // R8 R9 R10 R11 enable map table
    for (int i = 0; i < 8; i++) begin
      lcd_vmode = VECS[i].vm; ce_halt = VECS[i].halt; pll_fast = VECS[i].fast;
      go(VECS[i].m);
      tick(1);
      check("R3 mode reached", pm_mode, VECS[i].m);
      case (VECS[i].m)
        2'b11:   check("R8 sleep enables", fn_en, VECS[i].en);
        2'b10:   check("R9 display enables", fn_en, VECS[i].en);
        default: check("R10 awake enables", fn_en, VECS[i].en);
      endcase
      check("R11 clock select", clk_fast_sel, VECS[i].clkf);
    end
    lcd_vmode = 0; ce_halt = 0; pll_fast = 0;

    // R4 R2: supply ignored in sleep, wake lands in brown first
    go(2'b11);
    write_req(2'b10);
    check("R3 request in sleep ignored", pm_mode, 2'b11);
    main_pwr_ok = 1; tick(5);
    check("R2 supply ignored in sleep", pm_mode, 2'b11);
    pb_press = 1; tick(3);
    check("R4 wake to brown", pm_mode, 2'b01);
    check("R5 push-button flag", wake_flags, 5'h02);
    tick(1);
    check("R2 then run", pm_mode, 2'b00);
    pb_press = 0;

    // R5 edge pin already high at entry
    to_brn();
    gpio_edge_pin = 1; tick(3);
    write_req(2'b11);
    tick(5);
    check("R5 high edge pin no wake", pm_mode, 2'b11);
    check("R5 high edge pin no flag", wake_flags, 0);
    gpio_edge_pin = 0; tick(3);
    check("R5 falling edge pin no wake", pm_mode, 2'b11);
    gpio_edge_pin = 1; tick(3);
    check("R5 rising edge wake", pm_mode, 2'b01);
    check("R5 edge flag", wake_flags, 5'h04);
    gpio_edge_pin = 0;

    // R7 disabled level source, then enabled while held high
    wake_en = 5'b10111;
    go(2'b10);
    gpio_level_pin = 1; tick(5);
    check("R7 disabled source no wake", pm_mode, 2'b10);
    check("R7 disabled source no flag", wake_flags, 0);
    wake_en = 5'h1F; tick(1);
    check("R5 level wake", pm_mode, 2'b01);
    check("R5 level flag", wake_flags, 5'h08);
    gpio_level_pin = 0;

    // R5 receive activity on each line
    go(2'b11);
    uart_rx = 0; tick(3);
    check("R5 serial rx wake", pm_mode, 2'b01);
    check("R5 serial rx flag", wake_flags, 5'h10);
    uart_rx = 1;
    go(2'b10);
    opt_rx = 0; tick(3);
    check("R5 optical rx wake", pm_mode, 2'b01);
    check("R5 optical rx flag", wake_flags, 5'h10);
    opt_rx = 1;

    // R6 sticky, write-one-to-clear, set over clear
    tick(5);
    check("R6 flag sticky", wake_flags, 5'h10);
    wake_clr_wr = 1; wake_clr = 5'h01; tick(1);
    check("R6 other bit clear keeps flag", wake_flags, 5'h10);
    wake_clr = 5'h10; tick(1);
    check("R6 clear flag", wake_flags, 0);
    wake_clr_wr = 0; wake_clr = 0;
    pb_press = 1; tick(3);
    check("R6 no flag in brown", wake_flags, 0);
    pb_press = 0;
    go(2'b11);
    pb_press = 1; tick(2);
    wake_clr_wr = 1; wake_clr = 5'h02; tick(1);
    check("R6 set wins over clear", wake_flags, 5'h02);
    check("R4 brown after wake", pm_mode, 2'b01);
    wake_clr_wr = 0; wake_clr = 0; pb_press = 0;

    summary();
  end
endmodule